// File: doc/BRIEF.md
# Host-Programmed Serial Camera Control Bridge

This block puts a small bank of byte registers in front of a two-wire serial camera control master, so that a host can read or write one 8-bit register of an image sensor at a time. The host first sets an enable byte, the sensor's bus address and the target register index. For a write it also sets the byte to send. It then starts the operation by writing an opcode byte. While the transfer runs the host polls a status byte. When a read finishes, the byte fetched from the sensor is held in a read-result register.

The bus side drives two open-drain lines as pull-low enables: a low request for the clock line and one for the data line. The block also takes an input that returns the resolved level of the data line. A write sends a start condition, the address byte, the index byte and the data byte, then a stop. A read sends the address and the index, then a stop. It then sends a second start, the address with its low bit set, eight data bits from the sensor closed by a master not-acknowledge, and a final stop. Acknowledge bits from the sensor are not examined.

Top module: `sccb_bridge_ctl`

## Requirements
- R1: Registers sit in the 16-byte window at host address 0x200 by default. The offsets are: opcode +0 (reads 0), status +1, enable +2, bus address +3, write index +4, write value +5, read index +8 and read result +9. Each writable register reads back what was written. Unused offsets read 0, and writes outside the window have no effect.
- R2: Writing opcode 0x05 while idle sends START, the bus address with bit 0 cleared, the write index, the write value and STOP. Each byte goes MSB first, followed by one acknowledge slot in which the line is released.
- R3: Writing opcode 0x70 while idle sends START, the address with bit 0 cleared, the read index and STOP. It then sends START and the address with bit 0 set. It samples eight data bits MSB first, releases the line for the not-acknowledge and sends STOP. The sampled byte is then held in the read-result register.
- R4: In the cycle after an accepted opcode write, the status reads 0x00, and it stays 0x00 until the transfer ends.
- R5: A finished write sets the status to 0x04 and a finished read sets it to 0x01.
- R6: When the enable register holds 0x00 or 0x01, any opcode write sets the status to 0x80 and both bus lines stay released.
- R7: An opcode other than 0x05 or 0x70 sets the status to 0x80 and causes no bus activity.
- R8: Opcode writes made while a transfer runs are ignored. The running transfer, its status code and the sensor's register contents are unaffected.
- R9: Both lines are released when idle, and the clock and data lines never change in the same cycle. During a data bit the clock is high for 2*QDIV cycles.
- R10: After reset every register reads 0 and both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe; data returns next cycle |
| host_addr | input | AW | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| sioc_low | output | 1 | Pull the serial clock line low |
| siod_low | output | 1 | Pull the serial data line low |
| siod_in | input | 1 | Resolved level of the serial data line |

## Verification
The bench attaches a behavioural sensor to the resolved lines. The sensor decodes starts, stops and bytes, keeps its own register array and drives read data after clock falls. This lets a write followed by a read of the same index confirm the whole loop. If the address bit 0 were wrong, or the repeated start were missing on reads, the sensor log would hold the wrong byte sequence. A design that kept a stale status, or failed to clear it on an accepted opcode, shows a nonzero status on the first poll. A design that accepted an opcode while busy shows a second logged transfer or a read completion code. An enable decode that treated 0x01 as on would produce clock edges in a window where the bench requires quiet lines.

// File: rtl/sccb_bridge_pkg.sv
package sccb_bridge_pkg;
  localparam logic [3:0] OFS_OP    = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h1;
  localparam logic [3:0] OFS_EN    = 4'h2;
  localparam logic [3:0] OFS_SADDR = 4'h3;
  localparam logic [3:0] OFS_WIDX  = 4'h4;
  localparam logic [3:0] OFS_WVAL  = 4'h5;
  localparam logic [3:0] OFS_RIDX  = 4'h8;
  localparam logic [3:0] OFS_RVAL  = 4'h9;

  localparam logic [7:0] OPC_WRITE = 8'h05;
  localparam logic [7:0] OPC_READ  = 8'h70;

  localparam logic [7:0] ST_BUSY  = 8'h00;
  localparam logic [7:0] ST_WR_OK = 8'h04;
  localparam logic [7:0] ST_RD_OK = 8'h01;
  localparam logic [7:0] ST_ERR   = 8'h80;

  typedef enum logic [2:0] {K_START, K_TX, K_RX, K_STOP, K_END} item_e;
endpackage

// File: rtl/sccb_host_regs.sv
module sccb_host_regs
  import sccb_bridge_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          go,
  output logic          go_rd,
  output logic [7:0]    dev_addr,
  output logic [7:0]    reg_idx,
  output logic [7:0]    wr_byte,
  output logic [7:0]    status,
  output logic          inflight,
  input  logic          eng_done,
  input  logic [7:0]    eng_rdata
);
  logic [7:0] en_q, saddr_q, widx_q, wval_q, ridx_q, rval_q, stat_q, rdata_q;
  logic       go_q, oprd_q, infl_q;
  logic       hit, bus_on, opc_ok;
  logic [3:0] off;

  assign hit    = host_addr[AW-1:4] == BASE[AW-1:4];
  assign off    = host_addr[3:0];
  assign bus_on = en_q[7:1] != 7'd0;
  assign opc_ok = (host_wdata == OPC_WRITE) || (host_wdata == OPC_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; saddr_q <= '0; widx_q <= '0; wval_q <= '0;
      ridx_q <= '0; rval_q <= '0; stat_q <= ST_BUSY; rdata_q <= '0;
      go_q <= 1'b0; oprd_q <= 1'b0; infl_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      if (eng_done) begin
        infl_q <= 1'b0;
        stat_q <= oprd_q ? ST_RD_OK : ST_WR_OK;
        if (oprd_q) rval_q <= eng_rdata;
      end
      if (host_we && hit) begin
        case (off)
          OFS_EN:    en_q    <= host_wdata;
          OFS_SADDR: saddr_q <= host_wdata;
          OFS_WIDX:  widx_q  <= host_wdata;
          OFS_WVAL:  wval_q  <= host_wdata;
          OFS_RIDX:  ridx_q  <= host_wdata;
          OFS_OP: begin
            if (!infl_q) begin
              if (bus_on && opc_ok) begin
                go_q   <= 1'b1;
                oprd_q <= host_wdata == OPC_READ;
                infl_q <= 1'b1;
                stat_q <= ST_BUSY;
              end else begin
                stat_q <= ST_ERR;
              end
            end
          end
          default: ;
        endcase
      end
      if (host_re) begin
        if (!hit) rdata_q <= '0;
        else begin
          case (off)
            OFS_STAT:  rdata_q <= stat_q;
            OFS_EN:    rdata_q <= en_q;
            OFS_SADDR: rdata_q <= saddr_q;
            OFS_WIDX:  rdata_q <= widx_q;
            OFS_WVAL:  rdata_q <= wval_q;
            OFS_RIDX:  rdata_q <= ridx_q;
            OFS_RVAL:  rdata_q <= rval_q;
            default:   rdata_q <= '0;
          endcase
        end
      end
    end
  end

  assign host_rdata = rdata_q;
  assign go         = go_q;
  assign go_rd      = oprd_q;
  assign dev_addr   = saddr_q;
  assign reg_idx    = oprd_q ? ridx_q : widx_q;
  assign wr_byte    = wval_q;
  assign status     = stat_q;
  assign inflight   = infl_q;
endmodule

// File: rtl/sccb_bit_engine.sv
module sccb_bit_engine
  import sccb_bridge_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic       go_rd,
  input  logic [7:0] dev_addr,
  input  logic [7:0] reg_idx,
  input  logic [7:0] wr_byte,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic [7:0] rd_byte,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int DW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QDIV - 1);

  logic          act_q, rd_q, done_q, scl_lo_q, sda_lo_q;
  logic [3:0]    seg_q, bit_q, seg_nx;
  logic [1:0]    q_q;
  logic [DW-1:0] div_q;
  logic [7:0]    a_q, i_q, w_q, sh_q, cur, shifted;
  logic          tick, slot_end, bit_last, scl_n, sda_n;
  item_e         kind, kind_nx;

  function automatic item_e kind_of(input logic rd, input logic [3:0] s);
    if (rd) begin
      case (s)
        4'd0, 4'd4:       return K_START;
        4'd1, 4'd2, 4'd5: return K_TX;
        4'd6:             return K_RX;
        4'd3, 4'd7:       return K_STOP;
        default:          return K_END;
      endcase
    end else begin
      case (s)
        4'd0:             return K_START;
        4'd1, 4'd2, 4'd3: return K_TX;
        4'd4:             return K_STOP;
        default:          return K_END;
      endcase
    end
  endfunction

  assign kind     = kind_of(rd_q, seg_q);
  assign seg_nx   = seg_q + 4'd1;
  assign kind_nx  = kind_of(rd_q, seg_nx);
  assign tick     = act_q && (div_q == DIV_LAST);
  assign slot_end = tick && (q_q == 2'd3);
  assign bit_last = bit_q == 4'd8;

  always_comb begin
    case (seg_q)
      4'd1:    cur = {a_q[7:1], 1'b0};
      4'd2:    cur = i_q;
      4'd3:    cur = w_q;
      4'd5:    cur = {a_q[7:1], 1'b1};
      default: cur = 8'hFF;
    endcase
    shifted = cur << bit_q;
    scl_n = 1'b1;
    sda_n = 1'b1;
    if (act_q) begin
      case (kind)
        K_START: begin scl_n = q_q != 2'd3; sda_n = q_q < 2'd2; end
        K_TX:    begin scl_n = q_q == 2'd1 || q_q == 2'd2; sda_n = bit_last | shifted[7]; end
        K_RX:    begin scl_n = q_q == 2'd1 || q_q == 2'd2; sda_n = 1'b1; end
        K_STOP:  begin scl_n = q_q != 2'd0; sda_n = q_q[1]; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0; rd_q <= 1'b0; done_q <= 1'b0;
      seg_q <= '0; bit_q <= '0; q_q <= '0; div_q <= '0;
      a_q <= '0; i_q <= '0; w_q <= '0; sh_q <= '0;
      scl_lo_q <= 1'b0; sda_lo_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (go) begin
          act_q <= 1'b1; rd_q <= go_rd;
          seg_q <= '0; bit_q <= '0; q_q <= '0; div_q <= '0;
          a_q <= dev_addr; i_q <= reg_idx; w_q <= wr_byte;
        end
      end else begin
        div_q <= tick ? '0 : div_q + 1'b1;
        if (tick) q_q <= q_q + 2'd1;
        if (tick && q_q == 2'd1 && kind == K_RX && !bit_last)
          sh_q <= {sh_q[6:0], sda_in};
        if (slot_end) begin
          if ((kind == K_TX || kind == K_RX) && !bit_last) begin
            bit_q <= bit_q + 4'd1;
          end else begin
            bit_q <= '0;
            seg_q <= seg_nx;
            if (kind_nx == K_END) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      end
      scl_lo_q <= !scl_n;
      sda_lo_q <= !sda_n;
    end
  end

  assign busy    = act_q;
  assign done    = done_q;
  assign rd_byte = sh_q;
  assign scl_low = scl_lo_q;
  assign sda_low = sda_lo_q;
endmodule

// File: rtl/sccb_bridge_ctl.sv
module sccb_bridge_ctl #(
  parameter int AW = 12,
  parameter logic [AW-1:0] BASE = 12'h200,
  parameter int QDIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic          host_re,
  input  logic [AW-1:0] host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          sioc_low,
  output logic          siod_low,
  input  logic          siod_in
);
  logic       go_w, rdop_w, ebusy_w, edone_w, infl_w;
  logic [7:0] daddr_w, idx_w, wbyte_w, stat_w, erd_w;

  sccb_host_regs #(.AW(AW), .BASE(BASE)) u_regs (
    .clk(clk), .rst(rst),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .go(go_w), .go_rd(rdop_w), .dev_addr(daddr_w), .reg_idx(idx_w),
    .wr_byte(wbyte_w), .status(stat_w), .inflight(infl_w),
    .eng_done(edone_w), .eng_rdata(erd_w)
  );

  sccb_bit_engine #(.QDIV(QDIV)) u_eng (
    .clk(clk), .rst(rst),
    .go(go_w), .go_rd(rdop_w), .dev_addr(daddr_w), .reg_idx(idx_w),
    .wr_byte(wbyte_w), .sda_in(siod_in),
    .busy(ebusy_w), .done(edone_w), .rd_byte(erd_w),
    .scl_low(sioc_low), .sda_low(siod_low)
  );
endmodule

// File: rtl/sccb_bridge_chk.sv
module sccb_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       sioc_low,
  input logic       siod_low,
  input logic [7:0] status,
  input logic       start,
  input logic       rd_op,
  input logic       eng_busy,
  input logic       eng_done
);
  // R9
  lines_apart_chk: assert property (@(posedge clk) disable iff (rst)
    !(!$stable(sioc_low) && !$stable(siod_low)));
  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |=> (!sioc_low && !siod_low));
  // R6 R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (status == 8'h80) |-> (!eng_busy && !sioc_low && !siod_low));
  // R4
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> (status == 8'h00));
  // R4
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> eng_busy);
  // R5
  wr_code_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && !rd_op) |=> (status == 8'h04));
  // R5
  rd_code_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done && rd_op) |=> (status == 8'h01));
  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> !start);
endmodule

bind sccb_bridge_ctl sccb_bridge_chk u_chk (
  .clk(clk), .rst(rst), .sioc_low(sioc_low), .siod_low(siod_low),
  .status(stat_w), .start(go_w), .rd_op(rdop_w),
  .eng_busy(ebusy_w), .eng_done(edone_w)
);

// File: tb/sccb_bridge_ctl_tb.sv
module sccb_bridge_ctl_tb;
  localparam int QDIV = 4;
  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [11:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic sioc_low, siod_low, slv_drv = 1'b0;
  logic scl, sda;

  assign scl = !sioc_low;
  assign sda = !(siod_low || slv_drv);

  sccb_bridge_ctl #(.AW(12), .BASE(12'h200), .QDIV(QDIV)) u_dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sioc_low(sioc_low), .siod_low(siod_low), .siod_in(sda)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0, quiet = 0;
  int scl_falls = 0, hirun = 0, minhi = 1000;

  // behavioural sensor
  logic [7:0] mem [0:255];
  int log_q [$];
  logic ps = 1, psda = 1;
  int bc = 0, nb = 0, ob = 0;
  logic [7:0] sh = 0, ptr = 0, obyte = 0;
  bit arm = 0, outm = 0, ign = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && quiet) chk("R6/R7 quiet bus", {scl, sda}, 2'b11);
    if (scl) hirun++;
    if (ps && scl && psda && !sda) begin
      bc = 0; nb = 0; arm = 0; outm = 0; ign = 0; slv_drv = 0;
    end else if (ps && scl && !psda && sda) begin
      log_q.push_back(32'h100);
      bc = 0; nb = 0; arm = 0; outm = 0; ign = 0; slv_drv = 0;
    end else if (scl && !ps) begin
      hirun = 1;
      if (!outm && !ign) begin
        if (bc < 8) sh = {sh[6:0], sda};
        bc++;
        if (bc == 9) begin
          log_q.push_back(int'(sh));
          if (nb == 0 && sh[0]) begin arm = 1; obyte = mem[ptr]; end
          else if (nb == 1) ptr = sh;
          else if (nb == 2) mem[ptr] = sh;
          nb++; bc = 0;
        end
      end
    end else if (!scl && ps) begin
      scl_falls++;
      if (hirun < minhi) minhi = hirun;
      if (arm) begin
        arm = 0; outm = 1; ob = 7; slv_drv = !obyte[7];
      end else if (outm) begin
        if (ob == 0) begin slv_drv = 0; outm = 0; ign = 1; end
        else begin ob--; slv_drv = !obyte[ob]; end
      end
    end
    ps = scl; psda = sda;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hw(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1; host_addr = a;
    @(negedge clk); host_re = 0; d = host_rdata;
  endtask

  task automatic wait_done(output logic [7:0] s);
    s = 0;
    for (int k = 0; k < 5000; k++) begin
      hr(12'h201, s);
      if (s != 0) break;
    end
  endtask

  task automatic chk_log(string req, input int exp[$]);
    chk({req, " log length"}, log_q.size(), exp.size());
    for (int k = 0; k < exp.size() && k < log_q.size(); k++)
      chk({req, " log byte"}, log_q[k], exp[k]);
    log_q.delete();
  endtask

  initial begin
    logic [7:0] v;
    int f0;
    for (int k = 0; k < 256; k++) mem[k] = 8'(k) ^ 8'hA5;
    repeat (4) @(negedge clk);
    rst = 0;
    quiet = 1;
    // R10 reset state
    for (int o = 0; o < 10; o++) begin
      hr(12'h200 + 12'(o), v);
      chk("R10 reset reg", v, 0);
    end
    chk("R10 lines released", {sioc_low, siod_low}, 2'b00);

    // R1 register map and readback
    hw(12'h202, 8'h1E); hw(12'h203, 8'h60); hw(12'h204, 8'h20);
    hw(12'h205, 8'h3C); hw(12'h208, 8'h0A);
    hr(12'h202, v); chk("R1 enable", v, 8'h1E);
    hr(12'h203, v); chk("R1 address", v, 8'h60);
    hr(12'h204, v); chk("R1 write index", v, 8'h20);
    hr(12'h205, v); chk("R1 write value", v, 8'h3C);
    hr(12'h208, v); chk("R1 read index", v, 8'h0A);
    hr(12'h206, v); chk("R1 unused offset", v, 0);
    hw(12'h102, 8'h55);
    hr(12'h202, v); chk("R1 outside window", v, 8'h1E);

    // R7 unknown opcode
    f0 = scl_falls;
    hw(12'h200, 8'h33);
    hr(12'h201, v); chk("R7 unknown opcode status", v, 8'h80);
    chk("R7 no clock edges", scl_falls, f0);

    // R6 disabled bus, values 0 and 1
    hw(12'h202, 8'h00); hw(12'h200, 8'h05);
    repeat (40) @(negedge clk);
    hr(12'h201, v); chk("R6 enable 0 status", v, 8'h80);
    hw(12'h202, 8'h01); hw(12'h200, 8'h70);
    repeat (40) @(negedge clk);
    hr(12'h201, v); chk("R6 enable 1 status", v, 8'h80);
    chk("R6 no clock edges", scl_falls, f0);
    chk("R6 no bus bytes", log_q.size(), 0);
    quiet = 0;

    // R2 write transfer
    hw(12'h202, 8'h1E);
    minhi = 1000;
    hw(12'h200, 8'h05);
    hr(12'h201, v); chk("R4 status cleared after write opcode", v, 0);
    wait_done(v);
    chk("R5 write code", v, 8'h04);
    chk_log("R2", '{32'h60, 32'h20, 32'h3C, 32'h100});
    chk("R2 sensor register written", mem[8'h20], 8'h3C);
    chk("R9 clock high per data bit", minhi, 2 * QDIV);

    // R3 read of an untouched register
    hw(12'h200, 8'h70);
    hr(12'h201, v); chk("R4 status cleared after read opcode", v, 0);
    wait_done(v);
    chk("R5 read code", v, 8'h01);
    chk_log("R3", '{32'h60, 32'h0A, 32'h100, 32'h61, 32'h100});
    hr(12'h209, v); chk("R3 read result", v, 8'hAF);

    // R3 read back the written register, address bit 0 ignored
    hw(12'h203, 8'h61); hw(12'h208, 8'h20);
    hw(12'h200, 8'h70);
    wait_done(v);
    chk("R5 read code again", v, 8'h01);
    chk_log("R3 loop", '{32'h60, 32'h20, 32'h100, 32'h61, 32'h100});
    hr(12'h209, v); chk("R3 loop result", v, 8'h3C);

    // R8 opcodes while busy are ignored
    hw(12'h203, 8'h60); hw(12'h204, 8'h40); hw(12'h205, 8'h11);
    hw(12'h200, 8'h05);
    hw(12'h200, 8'h70);
    hw(12'h205, 8'h22);
    hw(12'h200, 8'h05);
    hw(12'h200, 8'h99);
    hr(12'h201, v); chk("R8 status still busy", v, 0);
    wait_done(v);
    chk("R8 completion is write", v, 8'h04);
    repeat (300) @(negedge clk);
    chk_log("R8", '{32'h60, 32'h40, 32'h11, 32'h100});
    chk("R8 sensor value", mem[8'h40], 8'h11);
    hr(12'h201, v); chk("R8 status unchanged later", v, 8'h04);
    hr(12'h209, v); chk("R8 read result kept", v, 8'h3C);
    chk("R9 lines idle", {sioc_low, siod_low}, 2'b00);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule